// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Sequencer

This block decides which descriptor of a circular ring a single DMA channel handles next, and when the channel stops and restarts. Software programs a ring base address, a ring length counted in descriptors, and a tail pointer. The tail points one descriptor past the last entry that software has handed to the engine. The sequencer keeps a current-descriptor pointer, which software can read. For each descriptor it issues one fetch request on a request/acknowledge port, and it moves the pointer forward only when that request is acknowledged.

The engine owns every descriptor from the current pointer up to the entry just before the tail. It stops by itself when the current pointer reaches the tail. It does not read an ownership flag inside each descriptor. A later tail write that leaves work pending restarts it at the current pointer. The same block serves a transmit ring or a receive ring. A parameter selects the direction; it changes only the direction tag on the fetch port, and the control behaviour is identical.

Top module: `desc_ring_seq`

## Requirements
- R1: After reset, the current pointer, the ring base and the tail are all 0x00000000, the ring length is 1, `fetch_req` is low, and `suspended` is high.
- R2: Each fetch presents the current pointer on `fetch_addr`. An acknowledged fetch advances the current pointer by 16, the descriptor size in bytes, and descriptors are fetched in ring order.
- R3: An acknowledged fetch of the descriptor at index length-1 (address base + 16*(length-1)) moves the current pointer back to the base address.
- R4: When the current pointer equals the tail, `fetch_req` stays low and `suspended` is high.
- R5: A tail write that leaves the current pointer unequal to the tail restarts fetching at the current pointer. This includes a wrapped tail whose address is numerically below the current pointer: fetching continues through the end of the ring and stops at the tail.
- R6: At most one fetch is outstanding. `fetch_req` stays high and the current pointer holds until `fetch_ack` is seen high at a clock edge while the request is high.
- R7: While `run_en` is low, no new fetch request is raised. A rising edge of `run_en` reloads the current pointer from the ring base.
- R8: A tail write in the same cycle as the acknowledge of the last owned descriptor is kept. Fetching resumes from the advanced pointer up to the new tail.
- R9: `fetch_dir` is constant: 0 for a transmit ring and 1 for a receive ring. It is set by the `DIR` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Start/stop control; a rising edge reloads the pointer from the base |
| base_we | input | 1 | Write strobe for the ring base register |
| base_wdata | input | ADDR_W | New ring base address |
| len_we | input | 1 | Write strobe for the ring length register |
| len_wdata | input | LEN_W | New ring length in descriptors |
| tail_we | input | 1 | Write strobe for the tail pointer |
| tail_wdata | input | ADDR_W | New tail address (one past the last owned descriptor) |
| cur_ptr | output | ADDR_W | Address of the current descriptor |
| suspended | output | 1 | High when idle because the current pointer equals the tail |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | ADDR_W | Address of the descriptor being requested |
| fetch_dir | output | 1 | Ring direction tag (0 transmit, 1 receive) |
| fetch_ack | input | 1 | Fetch acknowledge |

## Verification
The bench runs a chain of tail writes over several rings. The chain includes a ring that wraps and a tail placed numerically below the current pointer. A design that compared addresses by magnitude would stall there; one that forgot to wrap would fetch past the end of the ring. A tail write placed in the same cycle as the final acknowledge catches a design that samples the tail only when idle: it would lose the write and never fetch again. With `run_en` low and work pending, the bench checks that no request appears. It then checks that raising `run_en` restarts the fetches from the base and not from the old pointer.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } ring_dir_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ring_step.sv
// Computes the address of the descriptor after cur, wrapping to base.
module ring_step #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned OFF_W  = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  len,
   input  logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] next_addr
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << OFF_W;

   logic [ADDR_W-1:0] rel_idx;
   logic              at_last;

   always_comb begin
      rel_idx   = (cur - base) >> OFF_W;
      at_last   = (rel_idx == (ADDR_W'(len) - ADDR_W'(1)));
      next_addr = at_last ? base : (cur + STEP);
   end
endmodule

// File: rtl/fetch_handshake.sv
// Single-outstanding request holder: raised on launch, dropped on ack.
module fetch_handshake (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic ack,
   output logic req
);
   always_ff @(posedge clk) begin
      if (!rst_n)          req <= 1'b0;
      else if (req && ack) req <= 1'b0;
      else if (launch)     req <= 1'b1;
   end

   // R6: a pending request is held until acknowledged
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req);
endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq
   import desc_ring_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned DESC_BYTES = 16,
   parameter ring_dir_e   DIR        = DIR_TX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_wdata,
   input  logic              len_we,
   input  logic [LEN_W-1:0]  len_wdata,
   input  logic              tail_we,
   input  logic [ADDR_W-1:0] tail_wdata,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic              suspended,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_dir,
   input  logic              fetch_ack
);
   localparam int unsigned OFF_W = $clog2(DESC_BYTES);

   generate
      if (!is_pow2(DESC_BYTES))
         $error("DESC_BYTES must be a power of two");
      if (ADDR_W < OFF_W + LEN_W)
         $error("ADDR_W too narrow for the ring length");
      if (DIR == DIR_RX) begin : g_rx
         assign fetch_dir = 1'b1;
      end else begin : g_tx
         assign fetch_dir = 1'b0;
      end
   endgenerate

   logic [ADDR_W-1:0] base_q, tail_q, cur_q, next_addr;
   logic [LEN_W-1:0]  len_q;
   logic              run_q, start, done, launch;

   assign start  = run_en && !run_q;
   assign done   = fetch_req && fetch_ack;
   assign launch = run_en && run_q && !fetch_req && (cur_q != tail_q);

   ring_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_step (
      .base(base_q), .len(len_q), .cur(cur_q), .next_addr(next_addr)
   );

   fetch_handshake u_hs (
      .clk(clk), .rst_n(rst_n), .launch(launch), .ack(fetch_ack), .req(fetch_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= LEN_W'(1);
         tail_q <= '0;
         cur_q  <= '0;
         run_q  <= 1'b0;
      end else begin
         run_q <= run_en;
         if (base_we) base_q <= base_wdata;
         if (len_we)  len_q  <= len_wdata;
         if (tail_we) tail_q <= tail_wdata;
         if (start)      cur_q <= base_q;
         else if (done)  cur_q <= next_addr;
      end
   end

   assign cur_ptr    = cur_q;
   assign fetch_addr = cur_q;
   assign suspended  = !fetch_req && (cur_q == tail_q);

   logic [ADDR_W-1:0] last_addr;
   assign last_addr = base_q + ((ADDR_W'(len_q) - ADDR_W'(1)) << OFF_W);

   // R4: a new request only starts when there is owned work
   p_work_before_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_req) |-> $past(cur_q != tail_q));
   // R7: no request is raised while stopped
   p_quiet_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_req) |-> $past(run_en));
   // R6: pointer moves only on an acknowledge or a restart
   p_cur_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done && !start |=> $stable(cur_q));
   // R3: finishing the last descriptor returns to the base
   p_wrap_to_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start && !base_we && (cur_q == last_addr) |=> cur_q == base_q);
endmodule

// File: tb/desc_ring_seq_tb.sv
module desc_ring_seq_tb;
   localparam int AW = 32;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic          base_we = 1'b0, len_we = 1'b0, tail_we = 1'b0;
   logic [AW-1:0] base_wdata = '0, tail_wdata = '0;
   logic [LW-1:0] len_wdata = '0;
   logic [AW-1:0] cur_ptr, fetch_addr;
   logic          suspended, fetch_req, fetch_dir;
   logic          fetch_ack = 1'b0;

   int errs = 0;
   int checks = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   desc_ring_seq #(.ADDR_W(AW), .LEN_W(LW), .DESC_BYTES(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .base_we(base_we), .base_wdata(base_wdata),
      .len_we(len_we), .len_wdata(len_wdata),
      .tail_we(tail_we), .tail_wdata(tail_wdata),
      .cur_ptr(cur_ptr), .suspended(suspended),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_dir(fetch_dir), .fetch_ack(fetch_ack)
   );

   typedef struct packed {
      logic          restart;
      logic [AW-1:0] base;
      logic [LW-1:0] len;
      logic [LW-1:0] n;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b1, 32'h0000_1000, 8'd4, 8'd3},
      '{1'b0, 32'h0000_1000, 8'd4, 8'd3},
      '{1'b0, 32'h0000_1000, 8'd4, 8'd0},
      '{1'b1, 32'h0000_0080, 8'd8, 8'd7},
      '{1'b0, 32'h0000_0080, 8'd8, 8'd5},
      '{1'b1, 32'hFFF0_0000, 8'd3, 8'd2},
      '{1'b0, 32'hFFF0_0000, 8'd3, 8'd2},
      '{1'b1, 32'h0000_2000, 8'd1, 8'd0}
   };

   task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                      input logic [AW-1:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_base(input logic [AW-1:0] a);
      @(negedge clk); base_we = 1'b1; base_wdata = a;
      @(negedge clk); base_we = 1'b0;
   endtask
   task automatic wr_len(input logic [LW-1:0] l);
      @(negedge clk); len_we = 1'b1; len_wdata = l;
      @(negedge clk); len_we = 1'b0;
   endtask
   task automatic wr_tail(input logic [AW-1:0] a);
      @(negedge clk); tail_we = 1'b1; tail_wdata = a;
      @(negedge clk); tail_we = 1'b0;
   endtask

   task automatic restart_ring(input logic [AW-1:0] b, input logic [LW-1:0] l);
      @(negedge clk); run_en = 1'b0;
      wr_base(b); wr_len(l); wr_tail(b);
      run_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(cur_ptr == b, "R7 reload from base on start", cur_ptr, b);
   endtask

   // Acknowledges every request and checks addresses in ring order.
   task automatic serve(input logic [AW-1:0] b, input int len, input int idx0,
                        input int n, input string tag);
      int got = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (fetch_ack) fetch_ack = 1'b0;
         else if (fetch_req) begin
            logic [AW-1:0] exp;
            exp = b + AW'(((idx0 + got) % len) * 16);
            chk(fetch_addr == exp, {tag, " fetch address"}, fetch_addr, exp);
            got++;
            fetch_ack = 1'b1;
         end
      end
      @(negedge clk); fetch_ack = 1'b0;
      chk(got == n, {tag, " fetch count"}, AW'(got), AW'(n));
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errs++; checks++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] m_base, tail;
      int m_len, m_idx, seen;
      m_base = '0; m_len = 1; m_idx = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cur_ptr == 0, "R1 reset pointer", cur_ptr, 0);
      chk(suspended == 1'b1, "R1 reset suspended", AW'(suspended), 1);
      chk(fetch_req == 1'b0, "R1 reset request", AW'(fetch_req), 0);
      chk(fetch_dir == 1'b0, "R9 transmit direction tag", AW'(fetch_dir), 0);

      // Table walk: R2 in-order fetch, R3 wrap, R4 suspend, R5 wrapped tail
      for (int v = 0; v < 8; v++) begin
         if (VEC[v].restart) begin
            m_base = VEC[v].base; m_len = int'(VEC[v].len); m_idx = 0;
            restart_ring(m_base, VEC[v].len);
         end
         tail = m_base + AW'(((m_idx + int'(VEC[v].n)) % m_len) * 16);
         wr_tail(tail);
         serve(m_base, m_len, m_idx, int'(VEC[v].n), "R2 R3 R5");
         m_idx = (m_idx + int'(VEC[v].n)) % m_len;
         chk(cur_ptr == tail, "R2 R3 pointer ends at tail", cur_ptr, tail);
         chk(suspended == 1'b1, "R4 suspended at tail", AW'(suspended), 1);
      end

      // R7: stopped engine ignores pending work, then restarts from base
      restart_ring(32'h400, 8'd4);
      @(negedge clk); run_en = 1'b0;
      wr_tail(32'h430);
      seen = 0;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (fetch_req) seen++;
      end
      chk(seen == 0, "R7 no request while stopped", AW'(seen), 0);
      chk(cur_ptr == 32'h400, "R7 pointer held while stopped", cur_ptr, 32'h400);
      run_en = 1'b1;
      serve(32'h400, 4, 0, 3, "R7");
      chk(cur_ptr == 32'h430, "R7 pointer after restart", cur_ptr, 32'h430);

      // R8: tail write in the same cycle as the final acknowledge
      wr_tail(32'h400);
      seen = 0;
      for (int c = 0; c < 10 && !fetch_req; c++) @(negedge clk);
      chk(fetch_addr == 32'h430 && fetch_req, "R8 last owned descriptor", fetch_addr, 32'h430);
      fetch_ack = 1'b1; tail_we = 1'b1; tail_wdata = 32'h420;
      @(negedge clk);
      fetch_ack = 1'b0; tail_we = 1'b0;
      serve(32'h400, 4, 0, 2, "R8");
      chk(cur_ptr == 32'h420, "R8 resumed to new tail", cur_ptr, 32'h420);

      // R6: request held while not acknowledged
      wr_tail(32'h430);
      for (int c = 0; c < 10 && !fetch_req; c++) @(negedge clk);
      repeat (5) @(negedge clk);
      chk(fetch_req == 1'b1, "R6 request held without ack", AW'(fetch_req), 1);
      chk(cur_ptr == 32'h420, "R6 pointer held without ack", cur_ptr, 32'h420);
      serve(32'h400, 4, 2, 1, "R6");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule